// File: doc/BRIEF.md
# Edge-Flag Demodulator with Glitch Filter

This block sits at the input of a pulse demodulator. It takes one asynchronous input line and passes it through a two-flop synchronizer. A persistence filter follows, and its width is set by a 2-bit code. A pulse on the synchronized line that is not longer than the selected width never reaches the filtered output.

The filtered level is watched for transitions. A low-to-high change sets a sticky rising flag, and a high-to-low change sets a sticky falling flag. Each flag stays set until software writes a 1 into its bit through a small register write port. The flags can be read at any time. A one-cycle strobe marks every accepted transition, so nearby logic can react without polling.

Top module: `edge_flag_demod`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), both flags and `edge_strobe` are 0, and `filt_o` follows `sig_in`. When reset is released with `sig_in` unchanged, no flag gets set and no strobe occurs.
- R2: With `glitch_sel` = 00, no filtering is applied. A level that is driven on `sig_in` before rising edge k appears on `filt_o` after rising edge k+2 and not earlier. These three register stages are the two synchronizer flops and the filter output flop.
- R3: The hold lengths for `glitch_sel` are 00 → 0, 01 → 4, 10 → 8 and 11 → 16 clocks. A held level change on `sig_in` before edge k reaches `filt_o` after edge k+2+N, where N is the selected length.
- R4: A pulse on `sig_in` lasting N clocks or fewer is rejected, where N is the selected length. It changes neither `filt_o` nor the flags, and it raises no strobe. A pulse lasting N+1 clocks or more is passed.
- R5: A 0→1 change of `filt_o` sets `flags_o[0]` (the rising flag) in the same cycle.
- R6: A 1→0 change of `filt_o` sets `flags_o[1]` (the falling flag) in the same cycle.
- R7: A flag stays set until a cycle with `wr_en` = 1 and a 1 in the matching bit of `wr_data`. Bit 0 clears the rising flag and bit 1 clears the falling flag. A 0 in a bit leaves that flag unchanged.
- R8: When a flag is set by an edge and cleared by a write in the same cycle, it ends up set.
- R9: `edge_strobe` is high for exactly the cycle in which `filt_o` takes its new value, and it is low at all other times.
- R10: When the synchronized input returns to the filtered level before the hold length has passed, the hold count starts again from zero. Two sub-threshold pulses separated by a one-cycle gap are therefore both rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Raw asynchronous input line |
| glitch_sel | input | 2 | Glitch hold code: 00 none, 01 4, 10 8, 11 16 clocks |
| wr_en | input | 1 | Flag register write strobe |
| wr_data | input | 2 | Write-1-to-clear mask: bit 0 rising, bit 1 falling |
| flags_o | output | 2 | Sticky flags: bit 0 rising, bit 1 falling |
| edge_strobe | output | 1 | One-cycle pulse on each accepted edge |
| filt_o | output | 1 | Filtered, synchronized input level |

## Verification
The bench uses the default hold lengths of 4, 8 and 16. It probes each code at N and N+1 clocks, which covers both sides of every rejection boundary and the unfiltered single-cycle case. Because the lengths are short, the exact arrival cycle for the 8-clock setting can be counted edge by edge. A set-versus-clear collision can be lined up on one chosen edge with the unfiltered code. The restart rule is shown with two 3-cycle pulses under the 4-clock code.

// File: rtl/edge_flag_demod.sv
module edge_flag_demod #(
  parameter int LEN1 = 4,
  parameter int LEN2 = 8,
  parameter int LEN3 = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig_in,
  input  logic [1:0] glitch_sel,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  output logic [1:0] flags_o,
  output logic       edge_strobe,
  output logic       filt_o
);
  localparam int CW = $clog2(LEN3 + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt, lim;
  logic          differ, fire;
  logic [1:0]    set_v, clr_v;

  always_comb begin
    case (glitch_sel)
      2'b00:   lim = '0;
      2'b01:   lim = CW'(LEN1);
      2'b10:   lim = CW'(LEN2);
      default: lim = CW'(LEN3);
    endcase
  end

  assign differ = s2 != filt_o;
  assign fire   = differ && (cnt >= lim);
  assign set_v  = {fire & ~s2, fire & s2};
  assign clr_v  = wr_en ? wr_data : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1          <= sig_in;
      s2          <= sig_in;
      filt_o      <= sig_in;
      cnt         <= '0;
      flags_o     <= 2'b00;
      edge_strobe <= 1'b0;
    end else begin
      s1          <= sig_in;
      s2          <= s1;
      edge_strobe <= fire;
      flags_o     <= set_v | (flags_o & ~clr_v);
      if (fire) begin
        filt_o <= s2;
        cnt    <= '0;
      end else if (differ) begin
        cnt    <= cnt + 1'b1;
      end else begin
        cnt    <= '0;
      end
    end
  end

  a_r1_clean_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flags_o == 2'b00 && !edge_strobe));

  a_r9_strobe_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && filt_o != $past(filt_o)) |-> edge_strobe);

  a_r9_strobe_implies_change: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && edge_strobe) |-> filt_o != $past(filt_o));

  a_r5_rise_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_strobe && filt_o) |-> flags_o[0]);

  a_r6_fall_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_strobe && !filt_o) |-> flags_o[1]);

  a_r7_rise_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[0] && !(wr_en && wr_data[0])) |=> flags_o[0]);

  a_r7_fall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[1] && !(wr_en && wr_data[1])) |=> flags_o[1]);

  a_r7_rise_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0]) |=> (!flags_o[0] || (edge_strobe && filt_o)));

  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LEN3));
endmodule

// File: tb/tb_edge_flag_demod.sv
module tb_edge_flag_demod;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sig_in = 1'b0;
  logic [1:0] glitch_sel = 2'b00;
  logic       wr_en = 1'b0;
  logic [1:0] wr_data = 2'b00;
  logic [1:0] flags_o;
  logic       edge_strobe;
  logic       filt_o;

  int total = 0;
  int bad = 0;
  int nstrobe = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  edge_flag_demod dut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .glitch_sel(glitch_sel),
    .wr_en(wr_en), .wr_data(wr_data), .flags_o(flags_o),
    .edge_strobe(edge_strobe), .filt_o(filt_o)
  );

  always @(posedge clk) if (rst_n && edge_strobe) nstrobe <= nstrobe + 1;

  // {code, pulse length, expect pass}
  localparam logic [9:0] VEC [8] = '{
    {2'd0, 7'd1,  1'b1}, {2'd1, 7'd4,  1'b0}, {2'd1, 7'd5,  1'b1},
    {2'd2, 7'd8,  1'b0}, {2'd2, 7'd9,  1'b1}, {2'd3, 7'd16, 1'b0},
    {2'd3, 7'd17, 1'b1}, {2'd3, 7'd3,  1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    wr_en = 1'b1; wr_data = 2'b11;
    cyc(1);
    wr_en = 1'b0; wr_data = 2'b00;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset with input high
    sig_in = 1'b1;
    cyc(4);
    chk("R1 filt in reset", filt_o, 1);
    chk("R1 flags in reset", flags_o, 0);
    rst_n = 1'b1;
    nstrobe = 0;
    cyc(10);
    chk("R1 no flag after release", flags_o, 0);
    chk("R1 no strobe after release", nstrobe, 0);
    sig_in = 1'b0;
    cyc(30);
    clear_all();

    // R3 R4 table walk
    foreach (VEC[i]) begin
      glitch_sel = VEC[i][9:8];
      clear_all();
      nstrobe = 0;
      sig_in = 1'b1;
      cyc(int'(VEC[i][7:1]));
      sig_in = 1'b0;
      cyc(40);
      chk("R4 table strobes", nstrobe, VEC[i][0] ? 2 : 0);
      chk("R4 table flags", flags_o, VEC[i][0] ? 3 : 0);
    end

    // R2: unfiltered latency
    glitch_sel = 2'b00;
    clear_all();
    sig_in = 1'b1;
    cyc(2);
    chk("R2 not yet", filt_o, 0);
    cyc(1);
    chk("R2 arrives", filt_o, 1);
    chk("R5 rise flag", flags_o, 1);
    cyc(1);
    chk("R9 strobe one cycle", edge_strobe, 0);

    // R3 with code 10: arrives after edge k+10
    glitch_sel = 2'b10;
    clear_all();
    sig_in = 1'b0;
    cyc(10);
    chk("R3 not yet", filt_o, 1);
    chk("R9 no strobe early", edge_strobe, 0);
    cyc(1);
    chk("R3 arrives", filt_o, 0);
    chk("R9 strobe on change", edge_strobe, 1);
    chk("R6 fall flag", flags_o, 2);
    cyc(1);
    chk("R9 strobe drops", edge_strobe, 0);

    // R7: write 0 no effect, write 1 clears one bit
    glitch_sel = 2'b00;
    sig_in = 1'b1;
    cyc(5);
    chk("R7 both set", flags_o, 3);
    wr_en = 1'b1; wr_data = 2'b00;
    cyc(1);
    wr_en = 1'b0;
    chk("R7 write zero keeps", flags_o, 3);
    wr_en = 1'b1; wr_data = 2'b01;
    cyc(1);
    wr_en = 1'b0; wr_data = 2'b00;
    chk("R7 clear rise only", flags_o, 2);
    cyc(3);
    chk("R7 stays", flags_o, 2);

    // R8: set beats clear on same edge
    clear_all();
    sig_in = 1'b0;
    cyc(2);
    wr_en = 1'b1; wr_data = 2'b10;
    cyc(1);
    wr_en = 1'b0; wr_data = 2'b00;
    chk("R8 set wins", flags_o[1], 1);

    // R10: two 3-cycle pulses with 1-cycle gap under code 01
    glitch_sel = 2'b01;
    cyc(5);
    clear_all();
    nstrobe = 0;
    sig_in = 1'b1; cyc(3);
    sig_in = 1'b0; cyc(1);
    sig_in = 1'b1; cyc(3);
    sig_in = 1'b0; cyc(30);
    chk("R10 restart strobes", nstrobe, 0);
    chk("R10 restart flags", flags_o, 0);
    chk("R10 restart level", filt_o, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule